// File: doc/BRIEF.md
# Product Merge and Convergent Rounding Stage

This stage sits beside the multiplier of a DSP with a 40-bit accumulator. The multiplier leaves its product as four partial-sum fields: an 8-bit high field, two 16-bit middle terms and a 16-bit low field. This block folds those fields into a single 40-bit product. The two middle terms are added together before they are placed at bit 16. The block can also do the reverse and split a 40-bit packed product back into fields, with the second middle term cleared.

The same stage rounds a 40-bit operand to nearest, with ties to even, at bit 16. It keeps the upper 24 bits and adds one unit at bit 16 when the low half is above one half. On an exact tie it adds that unit only when bit 16 is odd. The sum wraps at 40 bits with no saturation. The stage also widens 16-, 32- and 40-bit quantities to the 64-bit internal width by sign extension.

A 3-bit operation code selects the work done in each cycle. Every output is registered, with one cycle of latency, and a synchronous active-high reset clears all outputs to zero.

Top module: `prodround_stage`

## Requirements
- R1: With op code 0 (merge), res_o one cycle later equals (hi_i·2^32 + (mid1_i + mid2_i)·2^16 + lo_i) mod 2^40, sign-extended from bit 39 to 64 bits.
- R2: With op code 1 (split), one cycle later hi_o = opnd_i[39:32], mid1_o = opnd_i[31:16], lo_o = opnd_i[15:0] and mid2_o = 0. res_o is 0 for this op.
- R3: With op code 2 (round), when opnd_i[15:0] < 0x8000, res_o one cycle later equals opnd_i sign-extended from bit 39, with nothing added.
- R4: With op code 2, when opnd_i[15:0] > 0x8000, res_o equals opnd_i + 0x10000, sign-extended from bit 39.
- R5: With op code 2, when opnd_i[15:0] == 0x8000, 0x10000 is added only if opnd_i[16] is 1. Otherwise nothing is added.
- R6: The rounded sum wraps modulo 2^40 before sign extension. No saturation is applied.
- R7: With op code 5, res_o is opnd_i sign-extended from bit 39: bits 63:40 copy bit 39.
- R8: With op code 3, res_o is opnd_i[15:0] sign-extended from bit 15. With op code 4, res_o is opnd_i[31:0] sign-extended from bit 31. Higher operand bits have no effect.
- R9: For every op code other than 1, the four field outputs are 0 one cycle later. For op codes 6 and 7, res_o is also 0.
- R10: Outputs change only on the rising clock edge, one cycle after their inputs are sampled. When rst_i is high at an edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 merge, 1 split, 2 round, 3 widen16, 4 widen32, 5 widen40, 6–7 reserved |
| hi_i | input | 8 | High partial-sum field |
| mid1_i | input | 16 | First middle partial-sum term |
| mid2_i | input | 16 | Second middle partial-sum term |
| lo_i | input | 16 | Low partial-sum field |
| opnd_i | input | 40 | Packed operand for split, round and widen operations |
| res_o | output | 64 | Registered 64-bit result |
| hi_o | output | 8 | Registered high field from a split |
| mid1_o | output | 16 | Registered first middle field from a split |
| mid2_o | output | 16 | Registered second middle field, always 0 |
| lo_o | output | 16 | Registered low field from a split |

## Verification
Merge is tried with field values at zero, one, mid-scale and all-ones. Pairs of full middle terms show whether the carry out of their 17-bit sum reaches bit 32. A saturated high field together with a middle carry shows whether the result wraps at 40 bits.

Rounding is swept across the low half in coarse steps and densely around 0x8000. Each point is tried with bit 16 at both values and with several upper patterns. This separates below-half, above-half and tie behaviour, and shows whether ties go to even or always up. Operands just under the 2^39 and 2^40 boundaries show whether the sum wraps and changes sign instead of saturating.

The widen operations use operands whose high unused bits disagree with the sign bit. This shows whether extension copies the right bit. Split, the reserved codes and a reset in the middle of a run check that each output is cleared or kept as its op code requires.

// File: rtl/prodround_pkg.sv
package prodround_pkg;

    // Accumulator, field and internal widths
    localparam int ACC_W = 40;
    localparam int FLD_W = 16;
    localparam int HI_W  = ACC_W - 2 * FLD_W;
    localparam int INT_W = 64;
    localparam int W16   = 16;
    localparam int W32   = 32;

    // Tie value of the discarded half for convergent rounding
    localparam logic [FLD_W-1:0] HALF_LSB = {1'b1, {(FLD_W-1){1'b0}}};

    typedef enum logic [2:0] {
        OP_MERGE  = 3'd0,
        OP_SPLIT  = 3'd1,
        OP_ROUND  = 3'd2,
        OP_WIDE16 = 3'd3,
        OP_WIDE32 = 3'd4,
        OP_WIDE40 = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } op_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [FLD_W-1:0] mid1;
        logic [FLD_W-1:0] mid2;
        logic [FLD_W-1:0] lo;
    } prod_fields_t;

    localparam prod_fields_t FIELDS_ZERO = '{default: '0};

    // True when every bit of a slice agrees with the sign bit
    function automatic logic upper_uniform(input logic [INT_W-1:0] v, input int from_bit);
        logic ones;
        logic zeros;
        ones  = 1'b1;
        zeros = 1'b1;
        for (int i = 0; i < INT_W; i++) begin
            if (i >= from_bit) begin
                ones  = ones & v[i];
                zeros = zeros & ~v[i];
            end
        end
        return ones | zeros;
    endfunction

endpackage

// File: rtl/prod_merge.sv
module prod_merge
    import prodround_pkg::*;
(
    input  prod_fields_t     fields_i,
    output logic [ACC_W-1:0] packed_o
);
    // Middle terms are summed first; the sum keeps its carry
    logic [FLD_W:0]   mid_sum;
    logic [ACC_W-1:0] hi_term;
    logic [ACC_W-1:0] mid_term;
    logic [ACC_W-1:0] lo_term;

    always_comb begin
        mid_sum  = {1'b0, fields_i.mid1} + {1'b0, fields_i.mid2};
        hi_term  = {fields_i.hi, {(2*FLD_W){1'b0}}};
        mid_term = ACC_W'(mid_sum) << FLD_W;
        lo_term  = ACC_W'(fields_i.lo);
        packed_o = hi_term + mid_term + lo_term;
    end

endmodule

// File: rtl/prod_split.sv
module prod_split
    import prodround_pkg::*;
(
    input  logic [ACC_W-1:0] packed_i,
    output prod_fields_t     fields_o
);
    always_comb begin
        fields_o.hi   = packed_i[ACC_W-1:2*FLD_W];
        fields_o.mid1 = packed_i[2*FLD_W-1:FLD_W];
        fields_o.mid2 = '0;
        fields_o.lo   = packed_i[FLD_W-1:0];
    end

endmodule

// File: rtl/conv_round.sv
module conv_round
    import prodround_pkg::*;
(
    input  logic [ACC_W-1:0] opnd_i,
    output logic             inc_o,
    output logic [ACC_W-1:0] rnd_o
);
    logic [FLD_W-1:0] frac;
    logic             above_half;
    logic             tie;
    logic             keep_odd;

    always_comb begin
        frac       = opnd_i[FLD_W-1:0];
        above_half = frac[FLD_W-1] & (|frac[FLD_W-2:0]);
        tie        = (frac == HALF_LSB);
        keep_odd   = opnd_i[FLD_W];
        inc_o      = above_half | (tie & keep_odd);
        // Wraps at the accumulator width; no saturation
        rnd_o      = opnd_i + (ACC_W'(inc_o) << FLD_W);
    end

endmodule

// File: rtl/sign_norm.sv
module sign_norm #(
    parameter int SRC_W = 16,
    parameter int DST_W = 64
) (
    input  logic [SRC_W-1:0] val_i,
    output logic [DST_W-1:0] ext_o
);
    for (genvar i = 0; i < DST_W; i++) begin : g_bit
        if (i < SRC_W) begin : g_keep
            assign ext_o[i] = val_i[i];
        end else begin : g_rep
            assign ext_o[i] = val_i[SRC_W-1];
        end
    end

endmodule

// File: rtl/prodround_stage.sv
module prodround_stage
    import prodround_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [2:0]         op_i,
    input  logic [HI_W-1:0]    hi_i,
    input  logic [FLD_W-1:0]   mid1_i,
    input  logic [FLD_W-1:0]   mid2_i,
    input  logic [FLD_W-1:0]   lo_i,
    input  logic [ACC_W-1:0]   opnd_i,
    output logic [INT_W-1:0]   res_o,
    output logic [HI_W-1:0]    hi_o,
    output logic [FLD_W-1:0]   mid1_o,
    output logic [FLD_W-1:0]   mid2_o,
    output logic [FLD_W-1:0]   lo_o
);
    op_e              op;
    prod_fields_t     in_fields;
    prod_fields_t     split_fields;
    logic [ACC_W-1:0] merged;
    logic [ACC_W-1:0] rounded;
    logic             rnd_inc;
    logic [INT_W-1:0] merged_ext;
    logic [INT_W-1:0] rounded_ext;
    logic [INT_W-1:0] wide16;
    logic [INT_W-1:0] wide32;
    logic [INT_W-1:0] wide40;
    logic [INT_W-1:0] res_d;
    prod_fields_t     fld_d;
    prod_fields_t     fld_q;
    logic [INT_W-1:0] res_q;

    assign op = op_e'(op_i);

    always_comb begin
        in_fields.hi   = hi_i;
        in_fields.mid1 = mid1_i;
        in_fields.mid2 = mid2_i;
        in_fields.lo   = lo_i;
    end

    prod_merge u_merge (
        .fields_i (in_fields),
        .packed_o (merged)
    );

    prod_split u_split (
        .packed_i (opnd_i),
        .fields_o (split_fields)
    );

    conv_round u_round (
        .opnd_i (opnd_i),
        .inc_o  (rnd_inc),
        .rnd_o  (rounded)
    );

    sign_norm #(.SRC_W(ACC_W), .DST_W(INT_W)) u_ext_merge (
        .val_i (merged),
        .ext_o (merged_ext)
    );

    sign_norm #(.SRC_W(ACC_W), .DST_W(INT_W)) u_ext_round (
        .val_i (rounded),
        .ext_o (rounded_ext)
    );

    sign_norm #(.SRC_W(W16), .DST_W(INT_W)) u_ext_16 (
        .val_i (opnd_i[W16-1:0]),
        .ext_o (wide16)
    );

    sign_norm #(.SRC_W(W32), .DST_W(INT_W)) u_ext_32 (
        .val_i (opnd_i[W32-1:0]),
        .ext_o (wide32)
    );

    sign_norm #(.SRC_W(ACC_W), .DST_W(INT_W)) u_ext_40 (
        .val_i (opnd_i),
        .ext_o (wide40)
    );

    // Operation select
    always_comb begin
        res_d = '0;
        fld_d = FIELDS_ZERO;
        unique case (op)
            OP_MERGE:  res_d = merged_ext;
            OP_SPLIT:  fld_d = split_fields;
            OP_ROUND:  res_d = rounded_ext;
            OP_WIDE16: res_d = wide16;
            OP_WIDE32: res_d = wide32;
            OP_WIDE40: res_d = wide40;
            default:   res_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            res_q <= '0;
            fld_q <= FIELDS_ZERO;
        end else begin
            res_q <= res_d;
            fld_q <= fld_d;
        end
    end

    assign res_o  = res_q;
    assign hi_o   = fld_q.hi;
    assign mid1_o = fld_q.mid1;
    assign mid2_o = fld_q.mid2;
    assign lo_o   = fld_q.lo;

    // R1
    merge_low_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_MERGE) |=> (res_o[FLD_W-1:0] == $past(lo_i)));

    // R1
    merge_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_MERGE) |=> upper_uniform(res_o, ACC_W - 1));

    // R2
    split_fields_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_SPLIT) |=> ({hi_o, mid1_o, lo_o} == $past(opnd_i)) && (mid2_o == '0) && (res_o == '0));

    // R3
    round_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (opnd_i[FLD_W-1:0] < HALF_LSB) |-> (rounded == opnd_i) && !rnd_inc);

    // R4
    round_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (opnd_i[FLD_W-1:0] > HALF_LSB) |-> (rounded[FLD_W-1:0] == opnd_i[FLD_W-1:0])
                                         && (rounded[ACC_W-1:FLD_W] == opnd_i[ACC_W-1:FLD_W] + 1'b1));

    // R5
    round_tie_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (opnd_i[FLD_W-1:0] == HALF_LSB) |-> (rnd_inc == opnd_i[FLD_W]) && !rounded[FLD_W]);

    // R8
    wide16_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op == OP_WIDE16) |=> upper_uniform(res_o, W16 - 1) && (res_o[W16-1:0] == $past(opnd_i[W16-1:0])));

    // R9
    fields_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op != OP_SPLIT) |=> (hi_o == '0) && (mid1_o == '0) && (mid2_o == '0) && (lo_o == '0));

    // R10
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (res_o == '0) && (hi_o == '0) && (mid1_o == '0) && (lo_o == '0));

endmodule

// File: tb/prodround_stage_test.sv
module prodround_stage_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk;
    logic        rst;
    logic [2:0]  op;
    logic [7:0]  hi;
    logic [15:0] mid1;
    logic [15:0] mid2;
    logic [15:0] lo;
    logic [39:0] opnd;
    logic [63:0] res;
    logic [7:0]  hi_q;
    logic [15:0] mid1_q;
    logic [15:0] mid2_q;
    logic [15:0] lo_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    prodround_stage uut (
        .clk_i  (clk),
        .rst_i  (rst),
        .op_i   (op),
        .hi_i   (hi),
        .mid1_i (mid1),
        .mid2_i (mid2),
        .lo_i   (lo),
        .opnd_i (opnd),
        .res_o  (res),
        .hi_o   (hi_q),
        .mid1_o (mid1_q),
        .mid2_o (mid2_q),
        .lo_o   (lo_q)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    localparam longint unsigned TWO16 = 64'd65536;
    localparam longint unsigned TWO32 = 64'd4294967296;
    localparam longint unsigned TWO40 = 64'd1099511627776;
    localparam longint unsigned TWO39 = 64'd549755813888;

    // Arithmetic sign extension of an n-bit value held in v (v < 2^n)
    function automatic longint unsigned sx(input longint unsigned v, input int n);
        longint unsigned lim;
        lim = 64'd1 << n;
        v = v % lim;
        if (v >= (lim >> 1)) return v - lim;
        return v;
    endfunction

    function automatic longint unsigned exp_merge(input longint unsigned h, input longint unsigned a,
                                                  input longint unsigned b, input longint unsigned l);
        return sx((h * TWO32 + (a + b) * TWO16 + l) % TWO40, 40);
    endfunction

    function automatic longint unsigned exp_round(input longint unsigned a);
        longint unsigned rem;
        longint unsigned inc;
        rem = a % TWO16;
        inc = 0;
        if (rem > 32768) inc = TWO16;
        else if (rem == 32768 && ((a / TWO16) % 2) == 1) inc = TWO16;
        return sx((a + inc) % TWO40, 40);
    endfunction

    task automatic check_res(input string tag, input longint unsigned expv);
        checks++;
        if (res !== expv) begin
            errors++;
            $display("FAIL %s: res actual=%h expected=%h", tag, res, expv);
        end
    endtask

    task automatic check_fld(input string tag, input logic [7:0] eh, input logic [15:0] e1,
                             input logic [15:0] e2, input logic [15:0] el);
        checks++;
        if ({hi_q, mid1_q, mid2_q, lo_q} !== {eh, e1, e2, el}) begin
            errors++;
            $display("FAIL %s: fields actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
                     tag, hi_q, mid1_q, mid2_q, lo_q, eh, e1, e2, el);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at the next falling edge
    task automatic run_op(input logic [2:0] o, input logic [7:0] h, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] l, input logic [39:0] x);
        op = o; hi = h; mid1 = a; mid2 = b; lo = l; opnd = x;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] mvals [4];
        logic [7:0]  hvals [5];
        logic [39:0] uppers [4];
        mvals  = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};
        hvals  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        uppers = '{40'h0, 40'h7F_FFFE_0000, 40'hFF_FFFE_0000, 40'h12_3456_0000};

        rst = 1'b1; op = 3'd0; hi = 8'hAA; mid1 = 16'h1234; mid2 = 16'h5678; lo = 16'h9ABC;
        opnd = 40'hFF_FFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        // R10: reset state
        check_res("R10 reset", 64'd0);
        check_fld("R10 reset", 8'h0, 16'h0, 16'h0, 16'h0);
        rst = 1'b0;

        // R1: merge sweep, fields cleared (R9)
        foreach (hvals[hi_ix]) foreach (mvals[a_ix]) foreach (mvals[b_ix])
            for (int l_ix = 0; l_ix < 2; l_ix++) begin
                logic [15:0] lv;
                lv = (l_ix == 0) ? 16'h0000 : 16'hFFFF;
                run_op(3'd0, hvals[hi_ix], mvals[a_ix], mvals[b_ix], lv, 40'hFF_FFFF_FFFF);
                check_res("R1 merge", exp_merge(hvals[hi_ix], mvals[a_ix], mvals[b_ix], lv));
                check_fld("R9 merge fields", 8'h0, 16'h0, 16'h0, 16'h0);
            end

        // R2: split patterns
        for (int k = 0; k < 40; k++) begin
            logic [39:0] x;
            x = (40'd1 << k) ^ 40'hA5_5AC3_3C0F;
            run_op(3'd1, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, x);
            check_fld("R2 split", x[39:32], x[31:16], 16'h0, x[15:0]);
            check_res("R2 split res", 64'd0);
        end

        // R3 R4 R5 R6: rounding sweep
        foreach (uppers[u_ix])
            for (int b16 = 0; b16 < 2; b16++) begin
                for (int f = 0; f < 65536; f += 257) begin
                    logic [39:0] x;
                    x = uppers[u_ix] | (40'(b16) << 16) | 40'(f);
                    run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, x);
                    check_res((f < 32768) ? "R3 round below half" :
                              (f > 32768) ? "R4 round above half" : "R5 round tie", exp_round(x));
                end
                for (int f = 32760; f <= 32776; f++) begin
                    logic [39:0] x;
                    x = uppers[u_ix] | (40'(b16) << 16) | 40'(f);
                    run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, x);
                    check_res((f == 32768) ? "R5 round tie" : "R3/R4 round near half", exp_round(x));
                end
            end
        // R6: wrap checks with explicit expected values
        run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, 40'hFF_FFFF_8001);
        check_res("R6 wrap to zero", 64'h0000_0000_0000_8001);
        run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, 40'h7F_FFFF_C000);
        check_res("R6 wrap positive to negative", 64'hFFFF_FF80_0000_C000);
        // R5: explicit tie cases
        run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, 40'h00_0002_8000);
        check_res("R5 tie even stays", 64'h0000_0000_0002_8000);
        run_op(3'd2, 8'h0, 16'h0, 16'h0, 16'h0, 40'h00_0003_8000);
        check_res("R5 tie odd rounds up", 64'h0000_0000_0004_8000);

        // R7 R8: widen operations
        for (int k = 0; k < 40; k++) begin
            logic [39:0] x;
            x = (40'd1 << k) | 40'h55_0000_0000;
            run_op(3'd3, 8'h0, 16'h0, 16'h0, 16'h0, x);
            check_res("R8 widen16", sx(64'(x) % TWO16, 16));
            run_op(3'd4, 8'h0, 16'h0, 16'h0, 16'h0, x);
            check_res("R8 widen32", sx(64'(x) % TWO32, 32));
            run_op(3'd5, 8'h0, 16'h0, 16'h0, 16'h0, x);
            check_res("R7 widen40", sx(64'(x), 40));
            check_fld("R9 widen fields", 8'h0, 16'h0, 16'h0, 16'h0);
        end
        run_op(3'd5, 8'h0, 16'h0, 16'h0, 16'h0, 40'h80_0000_0000);
        check_res("R7 widen40 sign", 64'hFFFF_FF80_0000_0000);
        run_op(3'd3, 8'h0, 16'h0, 16'h0, 16'h0, 40'hFF_FFFF_7FFF);
        check_res("R8 widen16 upper ignored", 64'h0000_0000_0000_7FFF);

        // R9: reserved codes after a split leaves fields nonzero
        run_op(3'd1, 8'h0, 16'h0, 16'h0, 16'h0, 40'hFE_DCBA_9876);
        check_fld("R2 split before reserved", 8'hFE, 16'hDCBA, 16'h0, 16'h9876);
        run_op(3'd6, 8'h11, 16'h2222, 16'h3333, 16'h4444, 40'hFE_DCBA_9876);
        check_res("R9 reserved6 res", 64'd0);
        check_fld("R9 reserved6 fields", 8'h0, 16'h0, 16'h0, 16'h0);
        run_op(3'd7, 8'h11, 16'h2222, 16'h3333, 16'h4444, 40'hFE_DCBA_9876);
        check_res("R9 reserved7 res", 64'd0);

        // R10: latency and mid-run reset
        run_op(3'd5, 8'h0, 16'h0, 16'h0, 16'h0, 40'h00_1234_5678);
        op = 3'd0; hi = 8'h01;
        #1;
        check_res("R10 output held until edge", 64'h0000_0000_1234_5678);
        @(negedge clk);
        check_res("R10 next edge takes new op", exp_merge(1, 0, 0, 0));
        run_op(3'd1, 8'h0, 16'h0, 16'h0, 16'h0, 40'hAB_CDEF_0123);
        rst = 1'b1;
        @(negedge clk);
        check_res("R10 mid-run reset res", 64'd0);
        check_fld("R10 mid-run reset fields", 8'h0, 16'h0, 16'h0, 16'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule